// File: doc/BRIEF.md
# Chien Search and Forney Error Correction Unit

This block is the final stage of a Reed-Solomon decoder over GF(2^8). It receives the error-locator polynomial and the error-evaluator polynomial for one codeword, already produced by an upstream stage. It also has read access to a buffer that holds the received symbols. The block runs a root search over the positions of a possibly shortened codeword. For each root it computes the error value with the Forney formula. It then streams the whole codeword out at one symbol per clock, with the errors removed.

The work is split into two passes. In the search pass, one candidate position is tested per clock. The pass stops as soon as the number of roots found equals the degree of the locator. In the emit pass, the block reads the received symbols from the buffer in transmission order and XORs each recorded error value onto its symbol.

If the number of roots found does not match the locator degree, the codeword is declared uncorrectable. In that case every symbol leaves the block unmodified and a fail flag is raised. The number of roots found is presented together with the last symbol. The field polynomial, the codeword length, the data length and the first generator root exponent are parameters. The root spacing is 1.

Top module: `rs_chien_forney`

## Requirements
- R1: After reset, `busy`, `out_valid`, `out_first`, `out_last`, `out_fail` and `err_cnt` are 0.
- R2: A `start` pulse seen while idle captures the locator coefficients and the evaluator coefficients. The locator has T+1 coefficients and the evaluator has T, where T=(N-K)/2. Coefficient i of each polynomial sits at bits [8i+7:8i]. Output index i (0 = first transmitted symbol) is polynomial degree j=N-1-i. The block reports an error at index i when the locator evaluates to zero at alpha^-j, with alpha = 2 in the field defined by `FIELD_POLY`.
- R3: At a root X=alpha^j, the error value is X^(1-GSTART)·Ω(X^-1)/Λ'(X^-1). It is XORed onto the symbol at index i. Symbols at non-root indices leave unchanged.
- R4: The search pass length L is defined as follows. L is 0 when the degree is 0. L is p+1 when the roots found reach the degree at index p. L is N otherwise. The first output symbol is visible after the (L+1)-th rising edge following the edge that samples `start`.
- R5: A block leaves as exactly N consecutive cycles of `out_valid`, read from buffer addresses 0..N-1 in order. `out_first` marks the first cycle and `out_last` marks the last.
- R6: When the number of roots found differs from the locator degree, `out_fail` is high for the whole block and all N symbols equal the buffer contents unmodified.
- R7: `err_cnt` equals the number of roots found within the N positions while `out_last` is high, and is 0 at all other times.
- R8: The locator degree is the index of its highest nonzero coefficient. With degree 0, no search is done, the block passes through unmodified, and `out_fail` stays low.
- R9: A `start` pulse while `busy` is high is ignored. The running block is unaffected and no further block follows it.
- R10: `busy` is high from the sampling edge until the edge that presents the last symbol, and is low from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin one codeword when idle |
| lambda_coefs | input | 8*(T+1) | Locator coefficients, coefficient i at bits 8i+7:8i |
| omega_coefs | input | 8*T | Evaluator coefficients, coefficient i at bits 8i+7:8i |
| rd_addr | output | clog2(N) | Read index into the received-symbol buffer |
| rd_data | input | 8 | Buffer symbol at `rd_addr`, same cycle |
| busy | output | 1 | Block is searching or emitting |
| out_valid | output | 1 | Output symbol valid |
| out_sym | output | 8 | Corrected (or unmodified) symbol |
| out_first | output | 1 | First symbol of the block |
| out_last | output | 1 | Last symbol of the block |
| out_fail | output | 1 | Root count did not match locator degree |
| err_cnt | output | clog2(T+1) | Roots found, valid with `out_last` |

## Verification
The bench builds locator and evaluator polynomials from chosen error positions and values, using its own field arithmetic and syndromes. It then compares the streamed symbols with the buffer contents XOR the chosen values.

A single error is swept over every position. This separates the position mapping and early-stop latency at each index. Pairs at a fixed spacing, and groups of three and four, exercise the Forney division with nontrivial derivative terms and the ordered use of the correction log.

Locators that carry a root beyond the shortened length separate the fail path from the correction path. An error-free locator shows the zero-length search. A start pulse injected mid-block shows that busy starts are ignored.

// File: rtl/rscf_pkg.sv
// Package: field arithmetic shared by the Chien/Forney unit.
// Assumes GF(2^8) with a primitive field polynomial given as a 9-bit value.
package rscf_pkg;

    typedef logic [7:0] gf_t;
    typedef logic [255:0][7:0] gf_tbl_t;

    // Multiply by alpha (x) modulo the field polynomial.
    function automatic gf_t gf_xtime(input gf_t a, input logic [8:0] poly);
        return {a[6:0], 1'b0} ^ (a[7] ? poly[7:0] : 8'h00);
    endfunction

    // General field multiply, shift-and-add.
    function automatic gf_t gf_mul(input gf_t a, input gf_t b, input logic [8:0] poly);
        gf_t acc;
        gf_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = gf_xtime(x, poly);
        end
        return acc;
    endfunction

    // alpha raised to a non-negative exponent.
    function automatic gf_t gf_alpha_pow(input int e, input logic [8:0] poly);
        gf_t r;
        r = 8'h01;
        for (int k = 0; k < (e % 255); k++) r = gf_xtime(r, poly);
        return r;
    endfunction

    // Table of multiplicative inverses, inv(0) defined as 0.
    function automatic gf_tbl_t gf_build_inv(input logic [8:0] poly);
        gf_tbl_t tbl;
        gf_tbl_t powers;
        gf_t     v;
        tbl    = '0;
        powers = '0;
        v      = 8'h01;
        for (int i = 0; i < 255; i++) begin
            powers[i] = v;
            v = gf_xtime(v, poly);
        end
        for (int i = 0; i < 255; i++) begin
            tbl[powers[i]] = powers[(255 - i) % 255];
        end
        return tbl;
    endfunction

endpackage

// File: rtl/gf8_inv_rom.sv
// Module: combinational field inverse lookup.
// Assumes the table is built at elaboration from FIELD_POLY; input 0 maps to 0.
module gf8_inv_rom
    import rscf_pkg::*;
#(
    parameter int unsigned FIELD_POLY = 285
) (
    input  logic [7:0] val_in,
    output logic [7:0] val_inv
);
    localparam logic [8:0] POLY = FIELD_POLY[8:0];
    localparam gf_tbl_t    INV_TBL = gf_build_inv(POLY);

    // Table read.
    assign val_inv = INV_TBL[val_in];

endmodule

// File: rtl/chien_term_bank.sv
// Module: bank of polynomial terms advanced by constant multipliers.
// Term i holds coef_i * alpha^(E_i*(idx-(NLEN-1))) with E_i=(i+OFFSET) mod 255,
// so the sum of all terms is the polynomial (times x^OFFSET) at alpha^-(NLEN-1-idx).
// Assumes load and step are never high together.
module chien_term_bank
    import rscf_pkg::*;
#(
    parameter int unsigned NTERM      = 5,
    parameter int unsigned OFFSET     = 0,
    parameter int unsigned NLEN       = 204,
    parameter int unsigned FIELD_POLY = 285
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [NTERM*8-1:0] coef_in,
    output logic [7:0]         sum_even,
    output logic [7:0]         sum_odd
);
    localparam logic [8:0] POLY  = FIELD_POLY[8:0];
    localparam int         SHIFT = (255 - ((NLEN - 1) % 255)) % 255;

    logic [NTERM*8-1:0] terms_flat;

    for (genvar i = 0; i < NTERM; i++) begin : g_term
        localparam int  EXP_STEP = (i + OFFSET) % 255;
        localparam int  EXP_INIT = (SHIFT * EXP_STEP) % 255;
        localparam gf_t C_STEP   = gf_alpha_pow(EXP_STEP, POLY);
        localparam gf_t C_INIT   = gf_alpha_pow(EXP_INIT, POLY);

        gf_t term_q;

        // Load the scaled coefficient or advance by one position.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                term_q <= '0;
            end else if (load) begin
                term_q <= gf_mul(coef_in[i*8 +: 8], C_INIT, POLY);
            end else if (step) begin
                term_q <= gf_mul(term_q, C_STEP, POLY);
            end
        end

        assign terms_flat[i*8 +: 8] = term_q;
    end

    // Split sum into even-index and odd-index terms.
    always_comb begin
        sum_even = '0;
        sum_odd  = '0;
        for (int i = 0; i < NTERM; i++) begin
            if (i % 2 == 1) sum_odd  = sum_odd  ^ terms_flat[i*8 +: 8];
            else            sum_even = sum_even ^ terms_flat[i*8 +: 8];
        end
    end

endmodule

// File: rtl/chien_err_log.sv
// Module: ordered log of (position, error value) pairs found by the search.
// Entries arrive in ascending position order, so a single read pointer
// walks the log while positions are emitted in the same order.
module chien_err_log
    import rscf_pkg::*;
#(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned IDX_W = 8,
    localparam int unsigned CW   = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_pos,
    input  logic [7:0]       wr_val,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CW-1:0]    count,
    output logic             hit,
    output logic [7:0]       hit_val
);
    logic [IDX_W-1:0] pos_q [SLOTS];
    gf_t              val_q [SLOTS];
    logic [CW-1:0]    count_q;
    logic [CW-1:0]    ptr_q;
    logic [IDX_W-1:0] cur_pos;
    gf_t              cur_val;

    // Append new entries and advance the read pointer on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            ptr_q   <= '0;
            for (int s = 0; s < SLOTS; s++) begin
                pos_q[s] <= '0;
                val_q[s] <= '0;
            end
        end else if (clear) begin
            count_q <= '0;
            ptr_q   <= '0;
        end else begin
            if (wr_en && (count_q < CW'(SLOTS))) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (CW'(s) == count_q) begin
                        pos_q[s] <= wr_pos;
                        val_q[s] <= wr_val;
                    end
                end
                count_q <= count_q + CW'(1);
            end
            if (rd_en && hit) ptr_q <= ptr_q + CW'(1);
        end
    end

    // Select the entry under the read pointer and compare with the index.
    always_comb begin
        cur_pos = '0;
        cur_val = '0;
        for (int s = 0; s < SLOTS; s++) begin
            if (CW'(s) == ptr_q) begin
                cur_pos = pos_q[s];
                cur_val = val_q[s];
            end
        end
        hit     = (ptr_q < count_q) && (cur_pos == rd_idx);
        hit_val = cur_val;
    end

    assign count = count_q;

    // The pointer never passes the number of stored entries (R3).
    assert_ptr_in_log_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= count_q);

    // The log never holds more than t entries (R7).
    assert_log_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(SLOTS));

endmodule

// File: rtl/rs_chien_forney.sv
// Module: root search and Forney correction for one GF(2^8) RS codeword.
// Pass 1 tests one position per clock and logs roots with their error values,
// stopping once the roots found equal the locator degree. Pass 2 reads the
// received buffer (combinational read) in order and applies the logged values,
// unless the root count disagreed with the degree. Root spacing is 1.
module rs_chien_forney
    import rscf_pkg::*;
#(
    parameter int unsigned N_LEN      = 204,
    parameter int unsigned K_LEN      = 188,
    parameter int unsigned GSTART     = 0,
    parameter int unsigned FIELD_POLY = 285,
    localparam int unsigned T_CORR    = (N_LEN - K_LEN) / 2,
    localparam int unsigned IDX_W     = $clog2(N_LEN),
    localparam int unsigned CNT_W     = $clog2(T_CORR + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [(T_CORR+1)*8-1:0] lambda_coefs,
    input  logic [T_CORR*8-1:0]   omega_coefs,
    output logic [IDX_W-1:0]      rd_addr,
    input  logic [7:0]            rd_data,
    output logic                  busy,
    output logic                  out_valid,
    output logic [7:0]            out_sym,
    output logic                  out_first,
    output logic                  out_last,
    output logic                  out_fail,
    output logic [CNT_W-1:0]      err_cnt
);
    localparam logic [8:0]       POLY     = FIELD_POLY[8:0];
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_LEN - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_EMIT} cf_state_t;

    cf_state_t        state_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] deg_q;
    logic [CNT_W-1:0] deg_in;
    logic             fail_q;
    logic             load;
    logic             step;
    logic             emit;
    logic [7:0]       lam_even, lam_odd, omg_even, omg_odd;
    logic [7:0]       lam_sum, omg_sum, odd_inv, magnitude;
    logic             loc_zero;
    logic             root_wr;
    logic [CNT_W-1:0] found;
    logic [CNT_W-1:0] found_next;
    logic             search_done;
    logic             hit;
    logic [7:0]       hit_val;

    assign load = (state_q == ST_IDLE) && start;
    assign step = (state_q == ST_SEARCH);
    assign emit = (state_q == ST_EMIT);

    // Locator degree: index of the highest nonzero coefficient.
    always_comb begin
        deg_in = '0;
        for (int i = 1; i <= T_CORR; i++) begin
            if (lambda_coefs[i*8 +: 8] != 8'h00) deg_in = CNT_W'(i);
        end
    end

    chien_term_bank #(
        .NTERM(T_CORR + 1), .OFFSET(0), .NLEN(N_LEN), .FIELD_POLY(FIELD_POLY)
    ) u_lambda (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .coef_in(lambda_coefs), .sum_even(lam_even), .sum_odd(lam_odd)
    );

    chien_term_bank #(
        .NTERM(T_CORR), .OFFSET(GSTART), .NLEN(N_LEN), .FIELD_POLY(FIELD_POLY)
    ) u_omega (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .coef_in(omega_coefs), .sum_even(omg_even), .sum_odd(omg_odd)
    );

    gf8_inv_rom #(.FIELD_POLY(FIELD_POLY)) u_inv (
        .val_in(lam_odd), .val_inv(odd_inv)
    );

    // Forney value: X^-GSTART*Omega(X^-1) over the odd part of Lambda at X^-1.
    always_comb begin
        lam_sum   = lam_even ^ lam_odd;
        omg_sum   = omg_even ^ omg_odd;
        loc_zero  = (lam_sum == 8'h00);
        magnitude = gf_mul(omg_sum, odd_inv, POLY);
    end

    assign root_wr     = step && loc_zero;
    assign found_next  = found + {{(CNT_W-1){1'b0}}, root_wr};
    assign search_done = step && ((root_wr && (found_next == deg_q)) || (idx_q == LAST_IDX));

    chien_err_log #(.SLOTS(T_CORR), .IDX_W(IDX_W)) u_log (
        .clk(clk), .rst_n(rst_n), .clear(load),
        .wr_en(root_wr), .wr_pos(idx_q), .wr_val(magnitude),
        .rd_en(emit), .rd_idx(idx_q),
        .count(found), .hit(hit), .hit_val(hit_val)
    );

    // Sequencer: idle, search pass, emit pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            deg_q   <= '0;
            fail_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        deg_q   <= deg_in;
                        idx_q   <= '0;
                        fail_q  <= 1'b0;
                        state_q <= (deg_in == '0) ? ST_EMIT : ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if (search_done) begin
                        idx_q   <= '0;
                        fail_q  <= (found_next != deg_q);
                        state_q <= ST_EMIT;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_EMIT: begin
                    if (idx_q == LAST_IDX) begin
                        idx_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output register stage for the emitted stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sym   <= '0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
            out_fail  <= 1'b0;
            err_cnt   <= '0;
        end else begin
            out_valid <= emit;
            out_sym   <= emit ? (rd_data ^ ((hit && !fail_q) ? hit_val : 8'h00)) : 8'h00;
            out_first <= emit && (idx_q == '0);
            out_last  <= emit && (idx_q == LAST_IDX);
            out_fail  <= emit && fail_q;
            err_cnt   <= (emit && (idx_q == LAST_IDX)) ? found : '0;
        end
    end

    assign rd_addr = idx_q;
    assign busy    = (state_q != ST_IDLE);

    // Search never continues once the roots reached the degree (R4).
    assert_search_below_deg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH) |-> (found < deg_q));

    // The stream is contiguous until its last symbol (R5).
    assert_stream_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid);

    // A new stream always opens with the first marker (R5).
    assert_stream_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_first);

    // The fail flag does not change inside a block (R6).
    assert_fail_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_first) |-> $stable(out_fail));

    // The count only appears with the last symbol (R7).
    assert_cnt_with_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != '0) |-> out_last);

    // The unit stays busy while a block is still being streamed (R10).
    assert_busy_mid_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> busy);

endmodule

// File: tb/tb_rs_chien_forney.sv
`timescale 1ns/1ps
module tb_rs_chien_forney;
    localparam int NB = 40;
    localparam int KB = 32;
    localparam int GB = 3;
    localparam int PB = 285;
    localparam int TB_T  = (NB - KB) / 2;
    localparam int IDX_W = $clog2(NB);
    localparam int CNT_W = $clog2(TB_T + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [(TB_T+1)*8-1:0] lambda_coefs = '0;
    logic [TB_T*8-1:0]     omega_coefs = '0;
    logic [IDX_W-1:0] rd_addr;
    logic [7:0] rd_data;
    logic busy, out_valid, out_first, out_last, out_fail;
    logic [7:0] out_sym;
    logic [CNT_W-1:0] err_cnt;

    logic [7:0] mem [NB];
    logic [7:0] exp_mem [NB];
    int ne;
    int ej [TB_T];
    logic [7:0] ev [TB_T];
    logic [7:0] lam [TB_T+1];
    logic [7:0] omg [TB_T];
    logic [7:0] syn [2*TB_T];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign rd_data = (int'(rd_addr) < NB) ? mem[rd_addr] : 8'h00;

    rs_chien_forney #(.N_LEN(NB), .K_LEN(KB), .GSTART(GB), .FIELD_POLY(PB)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .lambda_coefs(lambda_coefs), .omega_coefs(omega_coefs),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .out_valid(out_valid), .out_sym(out_sym), .out_first(out_first),
        .out_last(out_last), .out_fail(out_fail), .err_cnt(err_cnt)
    );

    function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
        int acc = 0;
        int x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ x;
            x = x << 1;
            if (x & 256) x = x ^ PB;
        end
        return acc[7:0];
    endfunction

    function automatic logic [7:0] bpow(input int e);
        logic [7:0] r = 8'h01;
        for (int k = 0; k < (e % 255); k++) r = bmul(r, 8'h02);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Locator = prod(1 + X_l x); syndromes S_m = sum Y_l X_l^(GB+m); Omega = S*Lambda mod x^2T.
    task automatic build_polys();
        for (int i = 0; i <= TB_T; i++) lam[i] = (i == 0) ? 8'h01 : 8'h00;
        for (int l = 0; l < ne; l++) begin
            logic [7:0] x = bpow(ej[l]);
            for (int i = TB_T; i >= 1; i--) lam[i] = lam[i] ^ bmul(x, lam[i-1]);
        end
        for (int m = 0; m < 2*TB_T; m++) begin
            syn[m] = 8'h00;
            for (int l = 0; l < ne; l++) syn[m] = syn[m] ^ bmul(ev[l], bpow((ej[l] * (GB + m)) % 255));
        end
        for (int i = 0; i < TB_T; i++) begin
            omg[i] = 8'h00;
            for (int a = 0; a <= i; a++) omg[i] = omg[i] ^ bmul(syn[a], lam[i-a]);
        end
    endtask

    task automatic run_block(input string tag, input bit inject);
        int exp_cnt = 0;
        int maxi = -1;
        bit exp_fail;
        int slen;
        int c = 0;
        int bad_sym = -1;
        logic [7:0] bad_act = 0;
        bit frame_ok = 1'b1;
        bit fail_ok = 1'b1;
        bit cnt_ok = 1'b1;
        bit busy_ok = 1'b1;
        int cnt_seen = 0;
        build_polys();
        for (int l = 0; l < ne; l++) begin
            if (ej[l] < NB) begin
                exp_cnt++;
                if (NB - 1 - ej[l] > maxi) maxi = NB - 1 - ej[l];
            end
        end
        exp_fail = (exp_cnt != ne);
        for (int i = 0; i < NB; i++) begin
            mem[i] = 8'($urandom);
            exp_mem[i] = mem[i];
        end
        if (!exp_fail)
            for (int l = 0; l < ne; l++) exp_mem[NB-1-ej[l]] = exp_mem[NB-1-ej[l]] ^ ev[l];
        slen = (ne == 0) ? 0 : (exp_fail ? NB : maxi + 1);
        for (int i = 0; i <= TB_T; i++) lambda_coefs[i*8 +: 8] = lam[i];
        for (int i = 0; i < TB_T; i++) omega_coefs[i*8 +: 8] = omg[i];
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!out_valid && c < 3*NB) begin @(negedge clk); c++; end
        chk(c == 1 + slen, "R4", {tag, " first-symbol latency"}, c, 1 + slen);
        for (int s = 0; s < NB; s++) begin
            if (out_sym !== exp_mem[s] && bad_sym < 0) begin bad_sym = s; bad_act = out_sym; end
            if (out_valid !== 1'b1 || out_first !== (s == 0) || out_last !== (s == NB-1)) frame_ok = 1'b0;
            if (out_fail !== exp_fail) fail_ok = 1'b0;
            if (s == NB-1) cnt_seen = int'(err_cnt);
            else if (err_cnt != 0) cnt_ok = 1'b0;
            if (busy !== (s != NB-1)) busy_ok = 1'b0;
            if (inject && s == 5) begin start = 1'b1; lambda_coefs = '1; end
            if (inject && s == 6) start = 1'b0;
            if (s < NB-1) @(negedge clk);
        end
        // R3 correction values, R2 position mapping, R6 unmodified data on fail
        chk(bad_sym < 0, exp_fail ? "R6" : "R3", {tag, " symbol value"},
            int'(bad_act), (bad_sym < 0) ? 0 : int'(exp_mem[bad_sym]));
        chk(frame_ok, "R5", {tag, " framing"}, frame_ok, 1);
        chk(fail_ok, "R6", {tag, " fail flag"}, fail_ok, 1);
        chk(cnt_ok && cnt_seen == exp_cnt, "R7", {tag, " error count"}, cnt_seen, exp_cnt);
        chk(busy_ok, "R10", {tag, " busy window"}, busy_ok, 1);
        @(negedge clk);
        chk(out_valid == 1'b0 && busy == 1'b0, "R5", {tag, " stream closed"}, out_valid, 0);
        if (inject) begin
            bit quiet = 1'b1;
            for (int w = 0; w < NB + 4; w++) begin
                if (out_valid || busy) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R9", "start while busy ignored", !quiet, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && out_valid == 0 && out_first == 0 && out_last == 0 && out_fail == 0 && err_cnt == 0,
            "R1", "outputs during reset", busy | out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && out_valid == 0 && err_cnt == 0, "R1", "idle after reset", busy | out_valid, 0);

        // R8 error-free locator
        ne = 0;
        run_block("R8 no errors", 1'b0);

        // R2 single error at every position
        for (int p = 0; p < NB; p++) begin
            ne = 1; ej[0] = p; ev[0] = 8'($urandom_range(255, 1));
            run_block("R2 single", 1'b0);
        end

        // R3 pairs at fixed spacing
        for (int p = 0; p < NB; p++) begin
            ne = 2; ej[0] = p; ej[1] = (p + 7) % NB;
            ev[0] = 8'($urandom_range(255, 1)); ev[1] = 8'($urandom_range(255, 1));
            run_block("R3 pair", 1'b0);
        end

        // R3 groups of three and four
        for (int r = 0; r < 10; r++) begin
            ne = 3; ej[0] = r; ej[1] = r + 13; ej[2] = r + 26;
            for (int l = 0; l < 3; l++) ev[l] = 8'($urandom_range(255, 1));
            run_block("R3 triple", 1'b0);
            ne = 4; ej[0] = r; ej[1] = r + 9; ej[2] = r + 19; ej[3] = r + 29;
            for (int l = 0; l < 4; l++) ev[l] = 8'($urandom_range(255, 1));
            run_block("R3 quad", 1'b0);
        end

        // R6 roots beyond the shortened length
        for (int r = 0; r < 6; r++) begin
            ne = 2; ej[0] = r * 5; ej[1] = NB + 20 * r;
            ev[0] = 8'($urandom_range(255, 1)); ev[1] = 8'($urandom_range(255, 1));
            run_block("R6 fail pair", 1'b0);
            ne = 1; ej[0] = NB + 3 + r;
            ev[0] = 8'($urandom_range(255, 1));
            run_block("R6 fail single", 1'b0);
        end

        // R9 start pulse during a running block
        ne = 2; ej[0] = 4; ej[1] = 30; ev[0] = 8'h5A; ev[1] = 8'hC3;
        run_block("R9 inject", 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule